// File: doc/BRIEF.md
# Stack Machine Fetch-Decode Sequencer

This block runs the front end of a stack-oriented abstract machine whose program store and data store are separate. It reads one 32-bit word from the program store at the current code pointer, latches that word into an instruction register and splits it into an opcode, a register selector, a word count and a signed displacement. It then checks the opcode against the legal set and hands each legal instruction to an execute stage over a valid/ready handshake. The execute stage returns the next code pointer when it has finished.

A machine status register gates all of this work. Fetching runs only while the status is "running". An undefined opcode moves the status to a fault value. A halt opcode moves it to "halted". A code pointer that lies at or beyond the code-top limit moves it to an address fault. Every state other than running is final until the next reset. After reset the code pointer is 0, and the word at address 0 is loaded into the instruction register before anything is issued.

Top module: `seq_fetch_ctrl`

## Requirements
- R1: After reset, status reads 0 (running) and `iss_valid` is low. The first program-store read goes to address 0 in the first cycle after reset is released, and the word at address 0 is the first instruction issued, with `iss_cp` = 0.
- R2: Each instruction word is split into four fields: opcode in bits 31:28, register selector in bits 27:24, count in bits 23:16, and displacement in bits 15:0. The fields appear on `iss_op`, `iss_rsel`, `iss_cnt` and `iss_disp`.
- R3: Opcode 9 is undefined. On fetching it, status becomes 2 (bad opcode) and nothing is issued. After a legal instruction is fetched and issued, status stays 0.
- R4: Opcode 15 is the halt opcode. On fetching it, status becomes 1 (halted), nothing is issued, and the program store is not read again.
- R5: No program-store read is made while status is not 0. Any non-zero status holds its value until reset.
- R6: When the code pointer is greater than or equal to `code_top`, status becomes 3 (bad code address) and no read is made at that address.
- R7: While `iss_valid` is high and `iss_ready` is low, `iss_valid` stays high and all issued fields and `iss_cp` stay unchanged.
- R8: The next fetch uses the code pointer returned on `ret_cp` with `ret_valid`, and `iss_cp` reports the address the issued instruction was fetched from.
- R9: The program store has one cycle of read latency. The first instruction after reset is issued in the third cycle after reset is released: read, capture, decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_top | input | CODE_AW | First code address that is out of range |
| code_rd | output | 1 | Program-store read strobe |
| code_addr | output | CODE_AW | Program-store read address |
| code_rdata | input | 32 | Read data, valid one cycle after `code_rd` |
| iss_valid | output | 1 | Decoded instruction offered to the execute stage |
| iss_ready | input | 1 | Execute stage accepts the instruction |
| iss_op | output | 4 | Opcode field |
| iss_rsel | output | 4 | Register selector field |
| iss_cnt | output | 8 | Count field |
| iss_disp | output | 16 | Signed displacement field |
| iss_cp | output | CODE_AW | Address of the issued instruction |
| ret_valid | input | 1 | Execute stage has finished and returns the next code pointer |
| ret_cp | input | CODE_AW | Next code pointer |
| status | output | 2 | Machine status: 0 running, 1 halted, 2 bad opcode, 3 bad code address |

## Verification
The bench builds the block with `CODE_AW` = 6, so a 64-word program store can be modelled completely. With that width, both a long jump and a jump that lands exactly on `code_top` fit inside the store. The legal-opcode mask and the halt opcode are left at their defaults. This lets the bench fetch opcode 9 as a real undefined code and opcode 15 as the terminating halt. Each fault is reached from a fresh reset, because every non-running status is final.

// File: rtl/seq_pkg.sv
// Shared field widths, status codes and the instruction field layout.
package seq_pkg;
    localparam int WORD_W = 32;
    localparam int OP_W   = 4;
    localparam int RSEL_W = 4;
    localparam int CNT_W  = 8;
    localparam int DISP_W = 16;

    typedef enum logic [1:0] {
        MS_RUN    = 2'd0,
        MS_HALTED = 2'd1,
        MS_BAD_OP = 2'd2,
        MS_BAD_CA = 2'd3
    } mstat_e;

    // Most significant member first: opcode sits in the top nibble.
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RSEL_W-1:0] rsel;
        logic [CNT_W-1:0]  cnt;
        logic [DISP_W-1:0] disp;
    } ifields_t;
endpackage

// File: rtl/seq_field_split.sv
// Splits an instruction word into its fields and classifies the opcode.
// Assumes: the word width equals the sum of the field widths.
module seq_field_split
    import seq_pkg::*;
#(
    parameter logic [(1<<OP_W)-1:0] LEGAL_MASK = 16'hFDFF,
    parameter logic [OP_W-1:0]      HALT_OP    = 4'd15
) (
    input  logic [WORD_W-1:0] word,
    output ifields_t          fields,
    output logic              legal,
    output logic              is_halt
);
    // Field extraction and opcode classification.
    always_comb begin
        fields  = ifields_t'(word);
        legal   = LEGAL_MASK[fields.op];
        is_halt = (fields.op == HALT_OP);
    end
endmodule

// File: rtl/seq_status_reg.sv
// Holds the machine status. Leaves running on the first fault or halt
// event and then keeps that value until reset.
// Assumes: at most one event is raised per cycle. If several are raised,
// the address fault wins, then the bad opcode, then the halt.
module seq_status_reg
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   set_bad_ca,
    input  logic   set_bad_op,
    input  logic   set_halt,
    output mstat_e stat
);
    // Sticky status update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= MS_RUN;
        else if (stat == MS_RUN) begin
            if (set_bad_ca)      stat <= MS_BAD_CA;
            else if (set_bad_op) stat <= MS_BAD_OP;
            else if (set_halt)   stat <= MS_HALTED;
        end
    end
endmodule

// File: rtl/seq_fetch_ctrl.sv
// Fetch and decode sequencer for a stack machine. Reads the program store
// at the code pointer, latches the word, decodes it and issues legal
// instructions over valid/ready. Waits for the next code pointer from
// the execute stage before fetching again.
// Assumes: read data arrives one cycle after code_rd; the execute stage
// returns exactly one ret_valid pulse per accepted instruction.
module seq_fetch_ctrl
    import seq_pkg::*;
#(
    parameter int                   CODE_AW    = 16,
    parameter logic [(1<<OP_W)-1:0] LEGAL_MASK = 16'hFDFF,
    parameter logic [OP_W-1:0]      HALT_OP    = 4'd15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_AW-1:0] code_top,
    output logic               code_rd,
    output logic [CODE_AW-1:0] code_addr,
    input  logic [WORD_W-1:0]  code_rdata,
    output logic               iss_valid,
    input  logic               iss_ready,
    output logic [OP_W-1:0]    iss_op,
    output logic [RSEL_W-1:0]  iss_rsel,
    output logic [CNT_W-1:0]   iss_cnt,
    output logic [DISP_W-1:0]  iss_disp,
    output logic [CODE_AW-1:0] iss_cp,
    input  logic               ret_valid,
    input  logic [CODE_AW-1:0] ret_cp,
    output logic [1:0]         status
);
    typedef enum logic [2:0] {
        PH_REQ, PH_WAIT, PH_DEC, PH_ISSUE, PH_EXEC, PH_STOP
    } phase_e;

    phase_e              ph;
    logic [CODE_AW-1:0]  cp;
    logic [WORD_W-1:0]   ir;
    ifields_t            f;
    logic                legal, is_halt, running, in_range;
    logic                set_bad_ca, set_bad_op, set_halt;
    mstat_e              stat;

    seq_field_split #(.LEGAL_MASK(LEGAL_MASK), .HALT_OP(HALT_OP)) u_split (
        .word(ir), .fields(f), .legal(legal), .is_halt(is_halt)
    );

    seq_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_bad_ca(set_bad_ca),
        .set_bad_op(set_bad_op), .set_halt(set_halt), .stat(stat)
    );

    // Fetch gating, fault events and issue outputs.
    always_comb begin
        running    = (stat == MS_RUN);
        in_range   = (cp < code_top);
        code_rd    = (ph == PH_REQ) && running && in_range;
        code_addr  = cp;
        set_bad_ca = (ph == PH_REQ) && running && !in_range;
        set_bad_op = (ph == PH_DEC) && !legal;
        set_halt   = (ph == PH_DEC) && legal && is_halt;
        iss_valid  = (ph == PH_ISSUE);
        iss_op     = f.op;
        iss_rsel   = f.rsel;
        iss_cnt    = f.cnt;
        iss_disp   = f.disp;
        iss_cp     = cp;
        status     = stat;
    end

    // Phase sequencing, instruction register and code pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_REQ;
            cp <= '0;
            ir <= '0;
        end else begin
            case (ph)
                PH_REQ:   ph <= (running && in_range) ? PH_WAIT : PH_STOP;
                PH_WAIT: begin
                    ir <= code_rdata;
                    ph <= PH_DEC;
                end
                PH_DEC:   ph <= (!legal || is_halt) ? PH_STOP : PH_ISSUE;
                PH_ISSUE: if (iss_ready) ph <= PH_EXEC;
                PH_EXEC: begin
                    if (ret_valid) begin
                        cp <= ret_cp;
                        ph <= PH_REQ;
                    end
                end
                default:  ph <= PH_STOP;
            endcase
        end
    end
endmodule

// File: rtl/seq_fetch_ctrl_chk.sv
// Property checker for seq_fetch_ctrl. It sees only the block's ports
// and is attached to every instance with bind.
module seq_fetch_ctrl_chk #(
    parameter int CODE_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CODE_AW-1:0] code_top,
    input logic               code_rd,
    input logic [CODE_AW-1:0] code_addr,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [3:0]         iss_op,
    input logic [3:0]         iss_rsel,
    input logic [7:0]         iss_cnt,
    input logic [15:0]        iss_disp,
    input logic [CODE_AW-1:0] iss_cp,
    input logic [1:0]         status
);
    assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op) &&
        $stable(iss_rsel) && $stable(iss_cnt) && $stable(iss_disp) && $stable(iss_cp)));

    assert_read_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_rd |-> (status == 2'd0));

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd0) |=> (status == $past(status)));

    assert_read_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_rd |-> (code_addr < code_top));

    assert_no_issue_undefined_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_op != 4'd9 && status == 2'd0));

    assert_no_issue_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_op != 4'd15));
endmodule

bind seq_fetch_ctrl seq_fetch_ctrl_chk #(.CODE_AW(CODE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .code_top(code_top), .code_rd(code_rd),
    .code_addr(code_addr), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_rsel(iss_rsel), .iss_cnt(iss_cnt),
    .iss_disp(iss_disp), .iss_cp(iss_cp), .status(status)
);

// File: tb/sim_seq_fetch_ctrl.sv
module sim_seq_fetch_ctrl;
    localparam int AW = 6;
    localparam int NV = 5;

    // Issuable program: word, then the expected fields.
    localparam logic [31:0] V_WORD [NV] = '{32'h05030010, 32'h30FFFFFF,
                                           32'hEF008000, 32'h84017FFF, 32'hAC5A1234};
    localparam logic [3:0]  V_OP   [NV] = '{4'd0, 4'd3, 4'd14, 4'd8, 4'd10};
    localparam logic [3:0]  V_RS   [NV] = '{4'd5, 4'd0, 4'd15, 4'd4, 4'd12};
    localparam logic [7:0]  V_CNT  [NV] = '{8'h03, 8'hFF, 8'h00, 8'h01, 8'h5A};
    localparam logic [15:0] V_DISP [NV] = '{16'h0010, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234};

    logic          clk = 0, rst_n = 0, iss_ready = 0, ret_valid = 0;
    logic [AW-1:0] code_top = 6'd60, ret_cp = '0;
    logic          code_rd, iss_valid;
    logic [AW-1:0] code_addr, iss_cp;
    logic [31:0]   code_rdata = '0;
    logic [3:0]    iss_op, iss_rsel;
    logic [7:0]    iss_cnt;
    logic [15:0]   iss_disp;
    logic [1:0]    status;
    logic [31:0]   mem [64];
    int            n_chk = 0, n_fail = 0, rd_cnt = 0;
    bit            done = 0;

    always #4 clk = ~clk;

    // Program store with one cycle of read latency.
    always @(posedge clk) begin
        if (code_rd) begin
            code_rdata <= mem[code_addr];
            rd_cnt     <= rd_cnt + 1;
        end
    end

    seq_fetch_ctrl #(.CODE_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .code_top(code_top), .code_rd(code_rd),
        .code_addr(code_addr), .code_rdata(code_rdata), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_op(iss_op), .iss_rsel(iss_rsel),
        .iss_cnt(iss_cnt), .iss_disp(iss_disp), .iss_cp(iss_cp),
        .ret_valid(ret_valid), .ret_cp(ret_cp), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; iss_ready = 0; ret_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Waits for an offer; returns the number of cycles waited.
    task automatic wait_offer(output int cyc);
        cyc = 0;
        @(negedge clk); cyc++;
        while (!iss_valid && cyc < 20) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic accept_and_return(input logic [AW-1:0] nxt);
        iss_ready = 1;
        @(negedge clk);
        iss_ready = 0; ret_valid = 1; ret_cp = nxt;
        @(negedge clk);
        ret_valid = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc, r0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h30000000;
        for (int i = 0; i < NV; i++) mem[i] = V_WORD[i];
        mem[NV] = 32'hF0000000;

        // R1: reset state and first read at address 0
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(status == 2'd0, "R1 status at reset", status, 0);
        chk(!iss_valid, "R1 no offer at reset", iss_valid, 0);
        rst_n = 1;
        #1;
        chk(code_rd && code_addr == 0, "R1 first read addr 0", code_addr, 0);

        // Table walk: R2 fields, R8 sequencing, R9 latency, R7 hold
        for (int i = 0; i < NV; i++) begin
            wait_offer(cyc);
            if (i == 0) chk(cyc == 3, "R9 first offer latency", cyc, 3);
            chk(iss_valid, "R8 offer seen", iss_valid, 1);
            chk(iss_op == V_OP[i], "R2 opcode field", iss_op, V_OP[i]);
            chk(iss_rsel == V_RS[i], "R2 register field", iss_rsel, V_RS[i]);
            chk(iss_cnt == V_CNT[i], "R2 count field", iss_cnt, V_CNT[i]);
            chk(iss_disp == V_DISP[i], "R2 displacement field", iss_disp, V_DISP[i]);
            chk(iss_cp == AW'(i), "R8 issued address", iss_cp, i);
            chk(status == 2'd0, "R3 running after legal fetch", status, 0);
            if (i == 1) begin
                repeat (3) @(negedge clk);
                chk(iss_valid && iss_op == V_OP[i] && iss_disp == V_DISP[i],
                    "R7 offer held under backpressure", iss_disp, V_DISP[i]);
            end
            accept_and_return(AW'(i + 1));
        end

        // R4: halt opcode at address NV
        repeat (4) @(negedge clk);
        chk(status == 2'd1, "R4 halted status", status, 1);
        r0 = rd_cnt;
        repeat (10) begin
            @(negedge clk);
            chk(!iss_valid, "R4 nothing issued after halt", iss_valid, 0);
        end
        chk(rd_cnt == r0, "R5 no read while halted", rd_cnt - r0, 0);

        // R3: undefined opcode 9
        mem[0] = 32'h9123ABCD;
        do_reset();
        r0 = 0;
        repeat (6) begin
            @(negedge clk);
            if (iss_valid) r0++;
        end
        chk(status == 2'd2, "R3 bad opcode status", status, 2);
        chk(r0 == 0, "R3 undefined opcode not issued", r0, 0);

        // R6: code pointer at limit from reset (code_top = 0)
        code_top = '0;
        r0 = rd_cnt;
        do_reset();
        repeat (3) @(negedge clk);
        chk(status == 2'd3, "R6 bad address from reset", status, 3);
        chk(rd_cnt == r0, "R6 no read beyond limit", rd_cnt - r0, 0);

        // R8 long jump, then R6 jump landing exactly on the limit
        code_top = 6'd60;
        mem[0]  = 32'h05030010;
        mem[40] = 32'hD2070042;
        do_reset();
        wait_offer(cyc);
        accept_and_return(6'd40);
        wait_offer(cyc);
        chk(iss_cp == 6'd40, "R8 fetch from returned pointer", iss_cp, 40);
        chk(iss_op == 4'd13 && iss_disp == 16'h0042, "R8 jumped word fields", iss_op, 13);
        r0 = rd_cnt;
        accept_and_return(6'd60);
        repeat (3) @(negedge clk);
        chk(status == 2'd3, "R6 jump onto limit faults", status, 3);
        chk(rd_cnt == r0, "R6 no read at limit", rd_cnt - r0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule